// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block sits next to a small processor core and decides which peripheral request it should take next. Each of up to 41 sources drives a one-cycle pulse that sets a sticky request flag. Each source also has an enable bit and a 3-bit priority field. The block picks the most urgent flagged, enabled source whose priority is above the core's current level. It presents that choice to the core as a request with a priority. When the core acknowledges, the block returns the source's vector number and the fetch address of its vector.

The core's 4-bit priority level is kept here. Acceptance raises it to the priority of the accepted source, and the previous value goes on a small stack. A return pulse pops the stack and restores the older level.

Two global controls shape acceptance:
- A no-nesting mode holds off every new request while any handler is active, and it freezes the level register against software writes.
- A timed mask counts retired instructions and, while it runs, blocks every source below the top priority.

A control bit chooses between a primary and an alternate vector table.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A pulse on `srcPulse[i]` sets flag bit i whether or not source i is enabled. Flags of source i read back at word address i/16, bit i%16. Enables use the same layout at word address 3 + i/16.
- R2: A register write to a flag word replaces its contents, which is how software clears flags. A source pulse in the same cycle as that write still leaves its bit set.
- R3: `irqReq` is high only when some source has its flag set, its enable set, a nonzero priority, and a priority strictly greater than `cpuLevel`. Priority 0 never requests. Source i's priority sits at address 6 + i/4, bits [4*(i%4)+2 : 4*(i%4)].
- R4: Among eligible sources the highest priority wins, and `irqPrio` reports it. On equal priority the lowest source index wins.
- R5: An acknowledge (`irqAck` while `irqReq`) makes `vecValid` high for exactly the following cycle. In that cycle `vecNum` is the winning index and `vecAddr` is base + 2*index. The base is the primary table base, or the alternate base when control bit 1 (address 17) is set.
- R6: On acknowledge, `cpuLevel` becomes the winner's priority and the previous level is saved. Each `retPulse` restores the most recently saved level, so nested handlers unwind in order.
- R7: While control bit 0 (no-nesting, address 17) is set and a handler is active, `irqReq` stays low even for a higher-priority source.
- R8: While no-nesting is set, writes to the level register (address 18, bits 3:0) are ignored. When it is clear, they load `cpuLevel`.
- R9: Writing N to address 19 opens a mask window lasting N pulses of `instrRetire`. During the window, control bit 2 reads 1 and sources of priority 1 to 6 cannot request, while priority-7 sources still can.
- R10: After reset all flags, enables, priorities, controls and the level are zero, and `irqReq` and `vecValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | 41 | One-cycle request pulses from the sources |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| instrRetire | input | 1 | One pulse per retired instruction |
| irqAck | input | 1 | Core accepts the presented request |
| retPulse | input | 1 | Core returned from a handler |
| irqReq | output | 1 | An eligible request is pending |
| irqPrio | output | 3 | Priority of the pending request |
| vecValid | output | 1 | Vector outputs valid (one cycle after acknowledge) |
| vecNum | output | 6 | Accepted source index |
| vecAddr | output | 24 | Program address of the accepted vector |
| cpuLevel | output | 4 | Current core priority level |

## Verification
The bench puts three sources of equal priority against each other. An arbiter with a reversed or missing tie rule would return index 9 or 40 instead of 5. The bench also acknowledges a priority-7 source inside a priority-6 handler and then unwinds with two return pulses. A level register without a save stack would fall straight to zero, or stay stuck at 7. The bench collides a flag-clearing write with a fresh pulse on the same bit, and a design that lets the write win would lose a request. It also checks that the mask window ends exactly on the Nth retired instruction, and that it lets priority 7 through. An off-by-one counter, or a mask that also blocks the top level, shows up there as a wrong `irqReq`.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = PRIO_W + 1;

  typedef struct packed {
    logic [LVL_W-1:0] cpuLevel;  // current core level for the compare
    logic             maskLow;   // timed window: only top priority may pass
    logic             holdOff;   // no request may be raised at all
  } pirq_gate_t;
endpackage

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int NUM_SRC = 41,
  parameter int WORD_W  = 16,
  parameter int AW      = 5,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               regWe,
  input  logic [AW-1:0]      regAddr,
  input  logic [WORD_W-1:0]  regWdata,
  input  pirq_gate_t         gate,
  output logic [WORD_W-1:0]  dpRdata,
  output logic               winValid,
  output logic [IDX_W-1:0]   winIdx,
  output logic [PRIO_W-1:0]  winPrio
);
  localparam int NUM_WORDS  = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int FIELD_W    = PRIO_W + 1;
  localparam int PER_WORD   = WORD_W / FIELD_W;
  localparam int NUM_PWORDS = (NUM_SRC + PER_WORD - 1) / PER_WORD;
  localparam int FLAG_BASE  = 0;
  localparam int EN_BASE    = NUM_WORDS;
  localparam int PRIO_BASE  = 2 * NUM_WORDS;
  localparam int TOT_W      = NUM_WORDS * WORD_W;

  logic [TOT_W-1:0]  flagQ, enQ, srcWide, validMask;
  logic [PRIO_W-1:0] prioQ [NUM_SRC];

  always_comb begin
    srcWide = '0;
    srcWide[NUM_SRC-1:0] = srcPulse;
    validMask = '0;
    validMask[NUM_SRC-1:0] = '1;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[w*WORD_W +: WORD_W] <= '0;
        enQ[w*WORD_W +: WORD_W]   <= '0;
      end else begin
        // a pulse from a source always beats a clearing write
        flagQ[w*WORD_W +: WORD_W] <=
          ((regWe && regAddr == AW'(FLAG_BASE + w)) ? regWdata : flagQ[w*WORD_W +: WORD_W])
          | (srcWide[w*WORD_W +: WORD_W] & validMask[w*WORD_W +: WORD_W]);
        if (regWe && regAddr == AW'(EN_BASE + w))
          enQ[w*WORD_W +: WORD_W] <= regWdata & validMask[w*WORD_W +: WORD_W];
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
    localparam int PW = s / PER_WORD;
    localparam int PS = s % PER_WORD;
    always_ff @(posedge clk) begin
      if (!rstN)
        prioQ[s] <= '0;
      else if (regWe && regAddr == AW'(PRIO_BASE + PW))
        prioQ[s] <= regWdata[PS*FIELD_W +: PRIO_W];
    end
  end

  always_comb begin
    dpRdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (regAddr == AW'(FLAG_BASE + w)) dpRdata = flagQ[w*WORD_W +: WORD_W];
      if (regAddr == AW'(EN_BASE + w))   dpRdata = enQ[w*WORD_W +: WORD_W];
    end
    for (int k = 0; k < NUM_PWORDS; k++) begin
      if (regAddr == AW'(PRIO_BASE + k)) begin
        for (int j = 0; j < PER_WORD; j++) begin
          if (k * PER_WORD + j < NUM_SRC)
            dpRdata[j*FIELD_W +: PRIO_W] = prioQ[k*PER_WORD + j];
        end
      end
    end
  end

  // strict ">" on the running best keeps the lowest index on a tie
  logic             anyElig;
  logic [IDX_W-1:0] bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  always_comb begin
    anyElig  = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (flagQ[s] && enQ[s] && prioQ[s] != '0
          && {1'b0, prioQ[s]} > gate.cpuLevel
          && !(gate.maskLow && prioQ[s] != '1)
          && prioQ[s] > bestPrio) begin
        anyElig  = 1'b1;
        bestIdx  = IDX_W'(s);
        bestPrio = prioQ[s];
      end
    end
    winValid = anyElig && !gate.holdOff;
    winIdx   = bestIdx;
    winPrio  = bestPrio;
  end
endmodule

// File: rtl/pirq_control.sv
module pirq_control
  import pirq_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int AW          = 5,
  parameter int IDX_W       = 6,
  parameter int CTL_ADDR    = 17,
  parameter int STACK_DEPTH = 8,
  parameter int WIN_W       = 14,
  parameter int VA_W        = 24,
  parameter logic [VA_W-1:0] PRI_BASE = 24'h000014,
  parameter logic [VA_W-1:0] ALT_BASE = 24'h000094
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [AW-1:0]      regAddr,
  input  logic [WORD_W-1:0]  regWdata,
  input  logic               instrRetire,
  input  logic               irqAck,
  input  logic               retPulse,
  input  logic               winValid,
  input  logic [IDX_W-1:0]   winIdx,
  input  logic [PRIO_W-1:0]  winPrio,
  output pirq_gate_t         gate,
  output logic [WORD_W-1:0]  ctlRdata,
  output logic               nestDis,
  output logic               irqReq,
  output logic [PRIO_W-1:0]  irqPrio,
  output logic               vecValid,
  output logic [IDX_W-1:0]   vecNum,
  output logic [VA_W-1:0]    vecAddr,
  output logic [LVL_W-1:0]   cpuLevel
);
  localparam int LVL_ADDR = CTL_ADDR + 1;
  localparam int WIN_ADDR = CTL_ADDR + 2;
  localparam int PTR_W    = $clog2(STACK_DEPTH);
  localparam int DEP_W    = $clog2(STACK_DEPTH + 1);

  logic             nestDisQ, altSelQ;
  logic [LVL_W-1:0] levelQ;
  logic [LVL_W-1:0] saveStack [STACK_DEPTH];
  logic [DEP_W-1:0] depthQ;
  logic [WIN_W-1:0] winCntQ;
  logic             inService, stackFull, take;

  assign inService = depthQ != '0;
  assign stackFull = depthQ == DEP_W'(STACK_DEPTH);
  assign gate.cpuLevel = levelQ;
  assign gate.maskLow  = winCntQ != '0;
  assign gate.holdOff  = (nestDisQ && inService) || stackFull;
  assign irqReq   = winValid;
  assign irqPrio  = winPrio;
  assign take     = irqAck && winValid;
  assign cpuLevel = levelQ;
  assign nestDis  = nestDisQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nestDisQ <= 1'b0;
      altSelQ  <= 1'b0;
      levelQ   <= '0;
      depthQ   <= '0;
      winCntQ  <= '0;
      vecValid <= 1'b0;
      vecNum   <= '0;
      vecAddr  <= '0;
    end else begin
      vecValid <= take;
      if (take) begin
        vecNum  <= winIdx;
        vecAddr <= (altSelQ ? ALT_BASE : PRI_BASE) + (VA_W'(winIdx) << 1);
      end
      // acknowledge outranks return, return outranks a software write
      if (take) begin
        depthQ <= depthQ + 1'b1;
        levelQ <= {1'b0, winPrio};
      end else if (retPulse && inService) begin
        depthQ <= depthQ - 1'b1;
        levelQ <= saveStack[PTR_W'(depthQ - 1'b1)];
      end else if (regWe && regAddr == AW'(LVL_ADDR) && !nestDisQ) begin
        levelQ <= regWdata[LVL_W-1:0];
      end
      if (regWe && regAddr == AW'(CTL_ADDR)) begin
        nestDisQ <= regWdata[0];
        altSelQ  <= regWdata[1];
      end
      if (regWe && regAddr == AW'(WIN_ADDR))
        winCntQ <= regWdata[WIN_W-1:0];
      else if (instrRetire && winCntQ != '0)
        winCntQ <= winCntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) saveStack[PTR_W'(depthQ)] <= levelQ;
  end

  always_comb begin
    ctlRdata = '0;
    if (regAddr == AW'(CTL_ADDR)) ctlRdata[2:0] = {gate.maskLow, altSelQ, nestDisQ};
    if (regAddr == AW'(LVL_ADDR)) ctlRdata[LVL_W-1:0] = levelQ;
    if (regAddr == AW'(WIN_ADDR)) ctlRdata[WIN_W-1:0] = winCntQ;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int NUM_SRC     = 41,
  parameter int WORD_W      = 16,
  parameter int AW          = 5,
  parameter int STACK_DEPTH = 8,
  parameter int WIN_W       = 14,
  parameter int VA_W        = 24,
  parameter logic [VA_W-1:0] PRI_BASE = 24'h000014,
  parameter logic [VA_W-1:0] ALT_BASE = 24'h000094,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               regWe,
  input  logic [AW-1:0]      regAddr,
  input  logic [WORD_W-1:0]  regWdata,
  output logic [WORD_W-1:0]  regRdata,
  input  logic               instrRetire,
  input  logic               irqAck,
  input  logic               retPulse,
  output logic               irqReq,
  output logic [PRIO_W-1:0]  irqPrio,
  output logic               vecValid,
  output logic [IDX_W-1:0]   vecNum,
  output logic [VA_W-1:0]    vecAddr,
  output logic [LVL_W-1:0]   cpuLevel
);
  localparam int NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int PER_WORD  = WORD_W / (PRIO_W + 1);
  localparam int CTL_ADDR  = 2 * NUM_WORDS + (NUM_SRC + PER_WORD - 1) / PER_WORD;

  pirq_gate_t        gateW;
  logic [WORD_W-1:0] dpRdata, ctlRdata;
  logic              winValid, nestDisW;
  logic [IDX_W-1:0]  winIdx;
  logic [PRIO_W-1:0] winPrio;

  pirq_datapath #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .AW(AW)) uDp (
    .clk, .rstN, .srcPulse, .regWe, .regAddr, .regWdata,
    .gate(gateW), .dpRdata, .winValid, .winIdx, .winPrio
  );

  pirq_control #(
    .WORD_W(WORD_W), .AW(AW), .IDX_W(IDX_W), .CTL_ADDR(CTL_ADDR),
    .STACK_DEPTH(STACK_DEPTH), .WIN_W(WIN_W), .VA_W(VA_W),
    .PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)
  ) uCtl (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .instrRetire, .irqAck, .retPulse,
    .winValid, .winIdx, .winPrio, .gate(gateW), .ctlRdata, .nestDis(nestDisW),
    .irqReq, .irqPrio, .vecValid, .vecNum, .vecAddr, .cpuLevel
  );

  assign regRdata = dpRdata | ctlRdata;
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker
  import pirq_pkg::*;
#(
  parameter int AW       = 5,
  parameter int LVL_ADDR = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic [PRIO_W-1:0] irqPrio,
  input logic              irqAck,
  input logic              retPulse,
  input logic              vecValid,
  input logic [LVL_W-1:0]  cpuLevel,
  input logic              regWe,
  input logic [AW-1:0]     regAddr,
  input logic              nestDis,
  input logic              holdOff,
  input logic              maskLow
);
  a_r3_req_above_level: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ({1'b0, irqPrio} > cpuLevel));

  a_r5_vec_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(irqAck && irqReq));

  a_r6_level_raised: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=> (cpuLevel == {1'b0, $past(irqPrio)}));

  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    holdOff |-> !irqReq);

  a_r8_level_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (nestDis && regWe && regAddr == AW'(LVL_ADDR) && !(irqAck && irqReq) && !retPulse)
      |=> $stable(cpuLevel));

  a_r9_window_top_only: assert property (@(posedge clk) disable iff (!rstN)
    (maskLow && irqReq) |-> (irqPrio == '1));
endmodule

bind prio_irq_ctrl pirq_checker #(.AW(AW), .LVL_ADDR(CTL_ADDR + 1)) uChk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqPrio(irqPrio), .irqAck(irqAck),
  .retPulse(retPulse), .vecValid(vecValid), .cpuLevel(cpuLevel), .regWe(regWe),
  .regAddr(regAddr), .nestDis(nestDisW), .holdOff(gateW.holdOff), .maskLow(gateW.maskLow)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NS = 41;
  localparam logic [23:0] PRI = 24'h000014;
  localparam logic [23:0] ALT = 24'h000094;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic [NS-1:0] srcPulse = '0;
  logic          regWe = 1'b0;
  logic [4:0]    regAddr = '0;
  logic [15:0]   regWdata = '0;
  logic [15:0]   regRdata;
  logic          instrRetire = 1'b0, irqAck = 1'b0, retPulse = 1'b0;
  logic          irqReq, vecValid;
  logic [2:0]    irqPrio;
  logic [5:0]    vecNum;
  logic [23:0]   vecAddr;
  logic [3:0]    cpuLevel;

  prio_irq_ctrl #(.PRI_BASE(PRI), .ALT_BASE(ALT)) dut (
    .clk, .rstN, .srcPulse, .regWe, .regAddr, .regWdata, .regRdata,
    .instrRetire, .irqAck, .retPulse, .irqReq, .irqPrio, .vecValid,
    .vecNum, .vecAddr, .cpuLevel
  );

  typedef struct packed { logic [5:0] num; logic [23:0] addr; } vec_t;
  vec_t expQ[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    vec_t e;
    if (rstN && vecValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 unexpected vecValid actual=1 expected=0");
      end else begin
        e = expQ.pop_front();
        chk("R5 vecNum", 32'(vecNum), 32'(e.num));
        chk("R5 vecAddr", 32'(vecAddr), 32'(e.addr));
      end
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = 5'(a); regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    regAddr = 5'(a); #1; d = regRdata;
  endtask

  task automatic pulse(input int s);
    @(negedge clk); srcPulse[s] = 1'b1;
    @(negedge clk); srcPulse = '0;
  endtask

  task automatic ack(input int num, input logic [23:0] base);
    @(negedge clk);
    expQ.push_back({6'(num), base + 24'(2 * num)});
    irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); retPulse = 1'b1;
    @(negedge clk); retPulse = 1'b0;
  endtask

  task automatic retire(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); instrRetire = 1'b1;
      @(negedge clk); instrRetire = 1'b0;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin : stim
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irqReq", 32'(irqReq), 0);
    chk("R10 cpuLevel", 32'(cpuLevel), 0);
    rd(0, d); chk("R10 flags", 32'(d), 0);
    chk("R10 vecValid", 32'(vecValid), 0);

    // R1 flag set while disabled; source 5 priority 3 at addr 7 bits 6:4
    wr(7, 16'h0030);
    pulse(5);
    rd(0, d); chk("R1 flag set without enable", 32'(d), 32'h0020);
    chk("R3 disabled source no req", 32'(irqReq), 0);
    wr(3, 16'h0020);
    chk("R3 enabled req", 32'(irqReq), 1);
    chk("R3 prio", 32'(irqPrio), 3);

    // R2 clear by write, then collision with a fresh pulse
    wr(0, 16'h0000);
    chk("R2 cleared", 32'(irqReq), 0);
    @(negedge clk); regWe = 1'b1; regAddr = 5'd0; regWdata = 16'h0000; srcPulse[5] = 1'b1;
    @(negedge clk); regWe = 1'b0; srcPulse = '0;
    rd(0, d); chk("R2 pulse beats clear", 32'(d), 32'h0020);
    wr(0, 16'h0000);

    // R3 priority 0 never requests: source 20 (word1 bit4), prio stays 0
    wr(4, 16'h0010);
    pulse(20);
    chk("R3 prio0 no req", 32'(irqReq), 0);

    // R4 tie at priority 3: sources 5, 9, 40
    wr(8, 16'h0030);           // src9 prio 3
    wr(16, 16'h0003);          // src40 prio 3
    wr(3, 16'h0220); wr(5, 16'h0100);
    pulse(5); pulse(9); pulse(40);
    chk("R4 tie prio", 32'(irqPrio), 3);
    ack(5, PRI);
    chk("R6 level after tie ack", 32'(cpuLevel), 3);
    ret();
    chk("R6 level restored", 32'(cpuLevel), 0);
    wr(16, 16'h0006);          // src40 prio 6 now wins
    chk("R4 highest wins", 32'(irqPrio), 6);
    ack(40, PRI);
    chk("R6 level 6", 32'(cpuLevel), 6);
    chk("R3 below level no req", 32'(irqReq), 0);

    // R6 nesting: source 12 prio 7 at addr 9 bits 2:0
    wr(9, 16'h0007); wr(3, 16'h1220);
    pulse(12);
    chk("R6 nested req", 32'(irqPrio), 7);
    ack(12, PRI);
    chk("R6 level 7", 32'(cpuLevel), 7);
    ret();
    chk("R6 unwind to 6", 32'(cpuLevel), 6);
    ret();
    chk("R6 unwind to 0", 32'(cpuLevel), 0);
    wr(0, 16'h0220); wr(2, 16'h0000);
    chk("R4 lowest index remains", 32'(irqPrio), 3);

    // R7 no-nesting blocks higher priority
    wr(17, 16'h0001);
    ack(5, PRI);
    pulse(12);
    chk("R7 blocked while in service", 32'(irqReq), 0);
    wr(18, 16'h0000);
    chk("R8 level write ignored", 32'(cpuLevel), 3);
    ret();
    chk("R7 req after return", 32'(irqPrio), 7);
    wr(17, 16'h0000);
    wr(18, 16'h0007);
    chk("R8 level write taken", 32'(cpuLevel), 7);
    chk("R3 equal level no req", 32'(irqReq), 0);
    wr(18, 16'h0000);

    // R9 mask window of 3 instructions
    wr(0, 16'h0220);
    wr(19, 16'h0003);
    rd(17, d); chk("R9 status set", 32'(d), 32'h4);
    chk("R9 low prio masked", 32'(irqReq), 0);
    pulse(12);
    chk("R9 prio7 passes", 32'(irqPrio), 7);
    chk("R9 prio7 req", 32'(irqReq), 1);
    wr(0, 16'h0220);
    retire(2);
    rd(17, d); chk("R9 still set", 32'(d), 32'h4);
    chk("R9 still masked", 32'(irqReq), 0);
    retire(1);
    rd(17, d); chk("R9 window ended", 32'(d), 0);
    chk("R9 req back", 32'(irqPrio), 3);

    // R5 alternate table
    wr(17, 16'h0002);
    ack(5, ALT);
    ret();
    wr(17, 16'h0000);

    repeat (3) @(negedge clk);
    chk("R5 all vectors seen", 32'(expQ.size()), 0);
    finishRun();
  end
endmodule